// File: doc/BRIEF.md
# Prescaled Masked Trigger Decision

This block turns a wide per-crossing vector of trigger conditions into eight global accept decisions. On every bunch-crossing beat it receives 128 algorithm condition bits and 64 technical condition bits. Every one of those 192 bits first passes through its own programmable rate reducer. Each reducer lets through the first asserted occurrence of its bit and then one occurrence out of every N. The reduced vector is sent out unchanged for rate counting and readout. In parallel it feeds eight independent decision planes. Each plane ORs the reduced bits that its enable mask selects, and it is blocked whenever any reduced technical bit selected by its own veto mask is set. In normal running only one of the eight decisions is used. The other seven are spares with the same structure.

The trigger stream is a valid-qualified stream with no back-pressure. A crossing cannot be stalled, so there is no ready signal: `in_valid` marks a beat, and every accepted beat produces exactly one output beat, flagged by `out_valid`, one clock later. A cycle with `in_valid` low is not a crossing. It advances no reducer, and its output beat is empty. Configuration is loaded through a plain write-only port of address, data and write enable.

Top module: `trig_decision`

## Requirements
- R1: A synchronous reset, `rst` high, does four things. It clears `out_valid`, `presc_bits` and `final_or`. It clears every reducer count. It sets every reduction ratio to 1, so every occurrence passes. It clears all enable and veto masks, so every `final_or` bit stays 0 until a mask is written.
- R2: Each input beat appears at the outputs one clock later: `out_valid` is `in_valid` delayed by one cycle. A cycle with `in_valid` low produces all-zero `presc_bits` and `final_or` on the following cycle, whatever the condition bits are. Such a cycle does not change any reducer count.
- R3: Bit i of `presc_bits` (0..127) is reduced algorithm bit i. Bit 128+j is reduced technical bit j (0..63). A bit of `presc_bits` can only be 1 if the matching input bit was 1 on a valid beat.
- R4: A ratio field written with value v (0..65535) selects a ratio N = v+1, from 1 up to 65536. Counting from reset, the bit's asserted occurrences number 1, 2, 3 and so on, and only valid beats with the bit at 1 count. With ratio N, occurrence k passes exactly when (k-1) mod N = 0.
- R5: A ratio may be rewritten to a value below the count the reducer has already reached since its last passed occurrence. In that case the next occurrence is blocked and the count restarts. The occurrence after the blocked one passes.
- R6: The eight outputs are formed independently. `final_or[o]` is the OR of all `presc_bits` enabled in mask o, ANDed with the inverse of the OR of the reduced technical bits enabled in veto mask o.
- R7: Write address bits [9:8] select a region, and bits [7:0] give an index k. Region 00 writes `cfg_wdata[15:0]` as ratio field k, for k < 192. Region 01 writes enable word k = 6·o + w, for k < 48; its data bit b enables `presc_bits` bit 32·w+b of output o. Region 10 writes veto word k = 2·o + w, for k < 16; its data bit b vetoes technical bit 32·w+b of output o. Region 11 and indices out of range change nothing. A write takes effect for the beat presented in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks a crossing beat on the condition inputs |
| alg_bits | input | 128 | Algorithm condition bits |
| tech_bits | input | 64 | Technical condition bits |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 10 | Configuration address: region [9:8], index [7:0] |
| cfg_wdata | input | 32 | Configuration write data |
| out_valid | output | 1 | Marks an output beat |
| presc_bits | output | 192 | Reduced condition vector: technical bits in [191:128], algorithm bits in [127:0] |
| final_or | output | 8 | Eight masked, vetoed decisions |

## Verification
The bench sweeps ratios 1 through 8 across all 192 bits and gives one bit the largest ratio, 65536. A reducer that counted idle beats or beats where its bit was low, or that passed the Nth occurrence instead of the first, would drift away from the arithmetic occurrence pattern. A separate sequence lowers a ratio below the count already reached. A reducer that compared only for equality would wrap through the whole 16-bit range there instead of restarting after one blocked occurrence. Outputs with full, empty and sparse enable and veto masks catch a plane that vetoes on raw instead of reduced bits, or that mixes up word-to-bit positions. Writes to the unused region and to out-of-range indices catch a decoder that aliases them onto real fields.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic [1:0] {
    RG_RATIO  = 2'b00,
    RG_ENABLE = 2'b01,
    RG_VETO   = 2'b10,
    RG_UNUSED = 2'b11
  } cfg_region_e;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_pkg::*;
#(
  parameter int N_ALG  = 128,
  parameter int N_TECH = 64,
  parameter int N_OUT  = 8,
  parameter int PW     = 16,
  parameter int AW     = 10,
  parameter int DW     = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_we,
  input  logic [AW-1:0]                    cfg_addr,
  input  logic [DW-1:0]                    cfg_wdata,
  output logic [N_ALG+N_TECH-1:0][PW-1:0]  ratio_m1,
  output logic [N_OUT-1:0][N_ALG+N_TECH-1:0] en_mask,
  output logic [N_OUT-1:0][N_TECH-1:0]     veto_mask
);

  localparam int N_TOT = N_ALG + N_TECH;
  localparam int IW    = AW - 2;
  localparam int EN_W  = ceil_div(N_TOT, DW);
  localparam int VT_W  = ceil_div(N_TECH, DW);
  localparam int N_ENW = N_OUT * EN_W;
  localparam int N_VTW = N_OUT * VT_W;

  cfg_region_e     region;
  logic [IW-1:0]   idx;
  logic [DW-1:0]   en_w [N_ENW];
  logic [DW-1:0]   vt_w [N_VTW];

  assign region = cfg_region_e'(cfg_addr[AW-1:AW-2]);
  assign idx    = cfg_addr[IW-1:0];

  // ratio fields, stored as ratio minus one
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_TOT; k++) ratio_m1[k] <= '0;
    end else if (cfg_we && region == RG_RATIO) begin
      for (int k = 0; k < N_TOT; k++)
        if (int'(idx) == k) ratio_m1[k] <= cfg_wdata[PW-1:0];
    end
  end

  // enable words
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_ENW; k++) en_w[k] <= '0;
    end else if (cfg_we && region == RG_ENABLE) begin
      for (int k = 0; k < N_ENW; k++)
        if (int'(idx) == k) en_w[k] <= cfg_wdata;
    end
  end

  // veto words
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_VTW; k++) vt_w[k] <= '0;
    end else if (cfg_we && region == RG_VETO) begin
      for (int k = 0; k < N_VTW; k++)
        if (int'(idx) == k) vt_w[k] <= cfg_wdata;
    end
  end

  // word storage to per-output bit masks
  for (genvar o = 0; o < N_OUT; o++) begin : g_map
    logic [EN_W*DW-1:0] en_flat;
    logic [VT_W*DW-1:0] vt_flat;
    for (genvar w = 0; w < EN_W; w++) begin : g_enw
      assign en_flat[w*DW +: DW] = en_w[o*EN_W + w];
    end
    for (genvar w = 0; w < VT_W; w++) begin : g_vtw
      assign vt_flat[w*DW +: DW] = vt_w[o*VT_W + w];
    end
    assign en_mask[o]   = en_flat[N_TOT-1:0];
    assign veto_mask[o] = vt_flat[N_TECH-1:0];
  end

  // R7: the unused region leaves every field untouched
  p_unused_region_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && region == RG_UNUSED) |=>
      ($stable(ratio_m1) && $stable(en_mask) && $stable(veto_mask)));

  // R7: no write, no change
  p_hold_without_write_r7: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> ($stable(ratio_m1) && $stable(en_mask) && $stable(veto_mask)));

endmodule

// File: rtl/trig_prescaler.sv
module trig_prescaler #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          occ,
  input  logic [PW-1:0] ratio_m1,
  output logic          pass
);

  logic [PW-1:0] cnt;

  // an occurrence passes when no occurrence is pending since the last pass
  assign pass = occ && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (occ) begin
      // >= also covers a ratio lowered below the current count (R5)
      if (cnt >= ratio_m1) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
    end
  end

  // R4: a passed occurrence with ratio above one leaves exactly one counted
  p_count_after_pass_r4: assert property (@(posedge clk) disable iff (rst)
    (occ && pass && ratio_m1 != '0) |=> (cnt == 1));

  // R2: without an occurrence the count holds
  p_idle_holds_r2: assert property (@(posedge clk) disable iff (rst)
    !occ |=> $stable(cnt));

endmodule

// File: rtl/trig_or_plane.sv
module trig_or_plane #(
  parameter int N_ALG  = 128,
  parameter int N_TECH = 64,
  parameter int SEG    = 32
) (
  input  logic [N_ALG+N_TECH-1:0] presc,
  input  logic [N_ALG+N_TECH-1:0] en,
  input  logic [N_TECH-1:0]       veto,
  output logic                    hit
);

  localparam int N_TOT = N_ALG + N_TECH;
  localparam int NSEG  = (N_TOT + SEG - 1) / SEG;

  logic [NSEG-1:0] seg_hit;
  logic            vetoed;

  // first level: per-segment masked OR, second level: OR of segments
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    localparam int LO = s * SEG;
    localparam int HI = ((LO + SEG) < N_TOT) ? (LO + SEG - 1) : (N_TOT - 1);
    assign seg_hit[s] = |(presc[HI:LO] & en[HI:LO]);
  end

  assign vetoed = |(presc[N_TOT-1:N_ALG] & veto);
  assign hit    = (|seg_hit) && !vetoed;

endmodule

// File: rtl/trig_decision.sv
module trig_decision #(
  parameter int N_ALG  = 128,
  parameter int N_TECH = 64,
  parameter int N_OUT  = 8,
  parameter int PW     = 16,
  parameter int AW     = 10,
  parameter int DW     = 32,
  parameter int SEG    = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [N_ALG-1:0]        alg_bits,
  input  logic [N_TECH-1:0]       tech_bits,
  input  logic                    cfg_we,
  input  logic [AW-1:0]           cfg_addr,
  input  logic [DW-1:0]           cfg_wdata,
  output logic                    out_valid,
  output logic [N_ALG+N_TECH-1:0] presc_bits,
  output logic [N_OUT-1:0]        final_or
);

  localparam int N_TOT = N_ALG + N_TECH;

  logic [N_TOT-1:0]           in_vec;
  logic [N_TOT-1:0]           occ;
  logic [N_TOT-1:0]           pass;
  logic [N_OUT-1:0]           hit;
  logic [N_TOT-1:0][PW-1:0]   ratio_m1;
  logic [N_OUT-1:0][N_TOT-1:0] en_mask;
  logic [N_OUT-1:0][N_TECH-1:0] veto_mask;

  assign in_vec = {tech_bits, alg_bits};
  assign occ    = in_vec & {N_TOT{in_valid}};

  trig_cfg_regs #(
    .N_ALG(N_ALG), .N_TECH(N_TECH), .N_OUT(N_OUT),
    .PW(PW), .AW(AW), .DW(DW)
  ) u_cfg (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ratio_m1(ratio_m1), .en_mask(en_mask), .veto_mask(veto_mask)
  );

  for (genvar i = 0; i < N_TOT; i++) begin : g_ps
    trig_prescaler #(.PW(PW)) u_ps (
      .clk(clk), .rst(rst), .occ(occ[i]),
      .ratio_m1(ratio_m1[i]), .pass(pass[i])
    );
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_plane
    trig_or_plane #(.N_ALG(N_ALG), .N_TECH(N_TECH), .SEG(SEG)) u_plane (
      .presc(pass), .en(en_mask[o]), .veto(veto_mask[o]), .hit(hit[o])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      presc_bits <= '0;
      final_or   <= '0;
    end else begin
      out_valid  <= in_valid;
      presc_bits <= pass;
      final_or   <= hit;
    end
  end

  // R2: one output beat per input beat, one cycle later
  p_beat_follows_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_gap_follows_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R2: an empty beat carries nothing
  p_empty_beat_r2: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (presc_bits == '0 && final_or == '0));

  // R3: a reduced bit needs its input bit on the previous beat
  p_subset_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((presc_bits & ~$past(in_vec)) == '0));

  // R6: a decision needs at least one reduced bit
  p_decision_has_source_r6: assert property (@(posedge clk) disable iff (rst)
    (final_or != '0) |-> (presc_bits != '0));

endmodule

// File: tb/trig_decision_bench.sv
module trig_decision_bench;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [127:0] alg_bits;
  logic [63:0]  tech_bits;
  logic         cfg_we;
  logic [9:0]   cfg_addr;
  logic [31:0]  cfg_wdata;
  logic         out_valid;
  logic [191:0] presc_bits;
  logic [7:0]   final_or;

  int total = 0;
  int bad   = 0;
  int occ [192];
  int rat [192];
  logic [191:0] en [8];
  logic [63:0]  vt [8];
  logic [31:0]  seed = 32'h1234_5678;

  always #4 clk = ~clk;

  trig_decision u_trig_decision (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .alg_bits(alg_bits), .tech_bits(tech_bits),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .presc_bits(presc_bits), .final_or(final_or)
  );

  task automatic chk(input string tag, input logic [191:0] act, input logic [191:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [191:0] rvec(input int dens);
    logic [191:0] v;
    for (int w = 0; w < 6; w++) begin
      logic [31:0] x;
      x = rnd();
      for (int d = 1; d < dens; d++) x = x & rnd();
      v[w*32 +: 32] = x;
    end
    return v;
  endfunction

  function automatic logic [7:0] exp_or(input logic [191:0] p);
    logic [7:0] r;
    for (int o = 0; o < 8; o++)
      r[o] = (|(p & en[o])) && !(|(p[191:128] & vt[o]));
    return r;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 192; i++) begin occ[i] = 0; rat[i] = 1; end
    for (int o = 0; o < 8; o++) begin en[o] = '0; vt[o] = '0; end
  endtask

  task automatic pulse_reset();
    in_valid = 1'b0; cfg_we = 1'b0; rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic cfg_write(input logic [1:0] rg, input int k, input logic [31:0] d);
    in_valid  = 1'b0;
    cfg_we    = 1'b1;
    cfg_addr  = {rg, 8'(k)};
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // present a beat at a negedge, check the outputs one negedge later
  task automatic apply(input logic v, input logic [191:0] vec,
                       input logic [191:0] ep, input logic [7:0] eo,
                       input string tp, input string to);
    in_valid = v;
    {tech_bits, alg_bits} = vec;
    @(negedge clk);
    chk("R2 out_valid", {191'b0, out_valid}, {191'b0, v});
    chk(tp, presc_bits, ep);
    chk(to, {184'b0, final_or}, {184'b0, eo});
  endtask

  task automatic drive(input logic v, input logic [191:0] vec, input string tp, input string to);
    logic [191:0] e;
    e = '0;
    for (int i = 0; i < 192; i++) begin
      if (v && vec[i]) begin
        if ((occ[i] % rat[i]) == 0) e[i] = 1'b1;
        occ[i]++;
      end
    end
    apply(v, vec, e, exp_or(e), tp, to);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    in_valid = 1'b0; alg_bits = '0; tech_bits = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    pulse_reset();

    // R1: reset state at the ports
    chk("R1 out_valid", {191'b0, out_valid}, '0);
    chk("R1 presc_bits", presc_bits, '0);
    chk("R1 final_or", {184'b0, final_or}, '0);

    // R1 / R3: default ratio 1 passes every bit in place, masks empty
    for (int n = 0; n < 20; n++) begin
      logic [191:0] v;
      v = rvec(1);
      drive(1'b1, v, "R3 pass-through", "R1 masks cleared");
    end

    // R2: idle beats carry nothing
    for (int n = 0; n < 5; n++)
      drive(1'b0, rvec(1), "R2 idle presc", "R2 idle or");

    // R5: lower a ratio below the reached count on bit 0
    cfg_write(2'b00, 0, 32'd3);  // ratio 4
    apply(1'b1, 192'd1, 192'd1, 8'd0, "R4 occ1 passes", "R5 or");
    apply(1'b1, 192'd1, 192'd0, 8'd0, "R4 occ2 blocked", "R5 or");
    apply(1'b1, 192'd1, 192'd0, 8'd0, "R4 occ3 blocked", "R5 or");
    cfg_write(2'b00, 0, 32'd1);  // ratio 2, count already 3
    apply(1'b1, 192'd1, 192'd0, 8'd0, "R5 blocked after shrink", "R5 or");
    apply(1'b1, 192'd1, 192'd1, 8'd0, "R5 restart passes", "R5 or");
    apply(1'b1, 192'd1, 192'd0, 8'd0, "R5 ratio 2 blocks", "R5 or");
    apply(1'b1, 192'd1, 192'd1, 8'd0, "R5 ratio 2 passes", "R5 or");

    // R1: reset restores ratio 1
    pulse_reset();
    drive(1'b1, 192'd1, "R1 ratio reset", "R1 or");
    drive(1'b1, 192'd1, "R1 ratio reset", "R1 or");

    // R4: ratios 1..8 across all bits, bit 3 at the maximum ratio
    for (int i = 0; i < 192; i++) begin
      rat[i] = (i % 8) + 1;
      if (i == 3) rat[i] = 65536;
      cfg_write(2'b00, i, 32'(rat[i] - 1));
    end

    // R6: masks - output 7 all enabled, output 6 empty, others sparse
    for (int o = 0; o < 8; o++) begin
      en[o] = (o == 7) ? '1 : (o == 6) ? '0 : rvec(3);
      vt[o] = (o == 7) ? '0 : rvec(4);
      for (int w = 0; w < 6; w++) cfg_write(2'b01, o * 6 + w, en[o][w*32 +: 32]);
      for (int w = 0; w < 2; w++) cfg_write(2'b10, o * 2 + w, vt[o][w*32 +: 32]);
    end

    // R7: writes that must land nowhere
    for (int k = 0; k < 4; k++) cfg_write(2'b11, k, 32'hFFFF_FFFF);
    cfg_write(2'b00, 200, 32'h0);
    cfg_write(2'b00, 255, 32'h0);
    for (int k = 48; k < 52; k++) cfg_write(2'b01, k, 32'hFFFF_FFFF);
    for (int k = 16; k < 20; k++) cfg_write(2'b10, k, 32'hFFFF_FFFF);

    // R4 / R6 / R7 sweep with idle beats mixed in
    for (int n = 0; n < 600; n++) begin
      logic v;
      v = (n % 5) != 4;
      drive(v, rvec(2), "R4 reduced vector", "R6 decisions");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule